// File: doc/BRIEF.md
# SPI Sensor Register Transaction Engine

This block performs one register access to an SPI-attached sensor. The sensor answers each request one frame later, so every access is two 32-bit frames. The first frame carries the request: an opcode byte that holds the register address and the read/write choice, a 16-bit data field sent big-endian, and a checksum byte. The second frame shifts out zeros while the reply is clocked in. Chip select goes high between the two frames, and again after the reply, for a minimum gap.

Once the reply is in, the engine checks the reply checksum and the 2-bit return status. It then presents the sign-extended 16-bit payload, a valid flag, a checksum-error flag and a device-error flag, and pulses `done`. A caller starts an access with a single-cycle `start` and waits for `done`. `busy` covers the whole access, including the gap after the reply.

Top module: `spi_frame_engine`

## Requirements
- R1: The request frame is `{opcode, data[15:8], data[7:0], check}`, shifted out MSB first. The opcode bit 7 is 1 for a write and 0 for a read, bits [6:2] hold the 5-bit register address, and bits [1:0] are 0. A read sends the `wr_data` input in its data field.
- R2: The check byte is a CRC-8 with polynomial 0x1D and seed 0xFF. It runs MSB first over the first 24 bits of the frame, and the result is bit-inverted.
- R3: During the second frame of an access, MOSI is 0 for all 32 bits.
- R4: Each frame has exactly 32 rising SCLK edges with chip select low. Chip select stays high for at least GAP_CYCLES clock cycles between the two frames, and after the reply before the next access.
- R5: SPI mode 0 applies. SCLK is low whenever chip select is high, and MOSI never changes in the cycle in which SCLK rises.
- R6: `rd_data` is reply bits [23:8] sign-extended to OUT_W bits. `rd_valid` is 1 when reply bits [7:0] equal the R2 checksum of reply bits [31:8].
- R7: A reply whose check byte does not match sets `crc_err` to 1 and `rd_valid` to 0.
- R8: `dev_err` is 1 when reply bits [25:24] equal 2'b11 and the checksum matches. Otherwise it is 0.
- R9: `busy` rises in the cycle after an accepted `start` and falls in the cycle in which `done` pulses. `done` lasts one cycle. The result outputs change only in that cycle. A `start` while `busy` is high has no effect.
- R10: After reset, chip select is high, SCLK is low, and `busy`, `done`, `rd_valid`, `crc_err` and `dev_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one access (taken only when idle) |
| wr_en | input | 1 | 1 selects a write, 0 a read |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Data field of the request |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | OUT_W | Sign-extended reply payload |
| rd_valid | output | 1 | Reply checksum matched |
| crc_err | output | 1 | Reply checksum mismatch |
| dev_err | output | 1 | Sensor reported error status |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to sensor |
| spi_miso | input | 1 | Serial data from sensor |

## Verification
The bench builds the engine with CLK_DIV=2 and GAP_CYCLES=20. These values keep a whole access near 300 cycles, so many reads, writes and error replies fit into one short run. The gap is small enough that the bench can measure the chip-select high time between frames and check it against the exact cycle count. A bus model on the SPI pins captures both frames bit by bit and serves scripted replies. Among them are negative payloads, a corrupted check byte and a fault status.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

    localparam int          FRAME_W  = 32;
    localparam int          ADDR_W   = 5;
    localparam int          DATA_W   = 16;
    localparam logic [7:0]  CRC_POLY = 8'h1D;
    localparam logic [7:0]  CRC_SEED = 8'hFF;
    localparam logic [1:0]  RS_FAULT = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_GAP,
        ST_RSP,
        ST_TAIL
    } eng_state_e;

    // Inverted CRC-8 over the 24-bit frame body, MSB first
    function automatic logic [7:0] frame_crc(input logic [23:0] body);
        logic [7:0] c;
        c = CRC_SEED;
        for (int i = 23; i >= 0; i--) begin
            if (c[7] ^ body[i]) c = {c[6:0], 1'b0} ^ CRC_POLY;
            else                c = {c[6:0], 1'b0};
        end
        return ~c;
    endfunction

endpackage

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (arm) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CW'(CYCLES - 1);
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = tmr_q.run && (tmr_q.cnt == '0);
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
    parameter int CLK_DIV = 4,
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               fin,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BW = $clog2(FRAME_W);

    typedef struct packed {
        logic               active;
        logic               sclk;
        logic               fin;
        logic [DW-1:0]      div;
        logic [BW-1:0]      bits;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        if (!s_q.active) begin
            if (go) begin
                s_d.active = 1'b1;
                s_d.sclk   = 1'b0;
                s_d.div    = '0;
                s_d.bits   = '0;
                s_d.tx     = tx_word;
            end
        end else if (s_q.div == DW'(CLK_DIV - 1)) begin
            s_d.div = '0;
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
                s_d.rx   = {s_q.rx[FRAME_W-2:0], miso};
            end else begin
                s_d.sclk = 1'b0;
                s_d.tx   = {s_q.tx[FRAME_W-2:0], 1'b0};
                if (s_q.bits == BW'(FRAME_W - 1)) begin
                    s_d.active = 1'b0;
                    s_d.fin    = 1'b1;
                end else begin
                    s_d.bits = s_q.bits + 1'b1;
                end
            end
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk    = s_q.sclk;
    assign mosi    = s_q.tx[FRAME_W-1];
    assign fin     = s_q.fin;
    assign rx_word = s_q.rx;
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_frame_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int GAP_CYCLES = 2000,
    parameter int OUT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_en,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       wr_data,
    output logic              busy,
    output logic              done,
    output logic [OUT_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              crc_err,
    output logic              dev_err,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int EXT_W = OUT_W - DATA_W;

    typedef struct packed {
        eng_state_e         st;
        logic               cs_n;
        logic               go;
        logic               arm;
        logic               done;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rsp;
        logic [OUT_W-1:0]   rdata;
        logic               rvalid;
        logic               crc_err;
        logic               dev_err;
    } eng_t;

    eng_t e_d, e_q;

    logic               shf_fin;
    logic [FRAME_W-1:0] shf_rx;
    logic               gap_done;
    logic [7:0]         req_op;
    logic [23:0]        req_body;
    logic               rsp_crc_ok;

    assign req_op     = {wr_en, reg_addr, 2'b00};
    assign req_body   = {req_op, wr_data};
    assign rsp_crc_ok = (e_q.rsp[7:0] == frame_crc(e_q.rsp[31:8]));

    always_comb begin
        e_d      = e_q;
        e_d.go   = 1'b0;
        e_d.arm  = 1'b0;
        e_d.done = 1'b0;
        unique case (e_q.st)
            ST_IDLE: if (start) begin
                e_d.tx   = {req_body, frame_crc(req_body)};
                e_d.go   = 1'b1;
                e_d.cs_n = 1'b0;
                e_d.st   = ST_REQ;
            end
            ST_REQ: if (shf_fin) begin
                e_d.cs_n = 1'b1;
                e_d.arm  = 1'b1;
                e_d.st   = ST_GAP;
            end
            ST_GAP: if (gap_done) begin
                e_d.tx   = '0;
                e_d.go   = 1'b1;
                e_d.cs_n = 1'b0;
                e_d.st   = ST_RSP;
            end
            ST_RSP: if (shf_fin) begin
                e_d.rsp  = shf_rx;
                e_d.cs_n = 1'b1;
                e_d.arm  = 1'b1;
                e_d.st   = ST_TAIL;
            end
            ST_TAIL: if (gap_done) begin
                e_d.rdata   = {{EXT_W{e_q.rsp[23]}}, e_q.rsp[23:8]};
                e_d.rvalid  = rsp_crc_ok;
                e_d.crc_err = !rsp_crc_ok;
                e_d.dev_err = rsp_crc_ok && (e_q.rsp[25:24] == RS_FAULT);
                e_d.done    = 1'b1;
                e_d.st      = ST_IDLE;
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.st   <= ST_IDLE;
            e_q.cs_n <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    spi_frame_shifter #(
        .CLK_DIV (CLK_DIV),
        .FRAME_W (FRAME_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (e_q.go),
        .tx_word (e_q.tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .fin     (shf_fin),
        .rx_word (shf_rx)
    );

    spi_gap_timer #(
        .CYCLES (GAP_CYCLES)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (e_q.arm),
        .expired (gap_done)
    );

    assign busy     = (e_q.st != ST_IDLE);
    assign done     = e_q.done;
    assign rd_data  = e_q.rdata;
    assign rd_valid = e_q.rvalid;
    assign crc_err  = e_q.crc_err;
    assign dev_err  = e_q.dev_err;
    assign spi_cs_n = e_q.cs_n;
endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk #(
    parameter int GAP_CYCLES = 2000,
    parameter int OUT_W      = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [OUT_W-1:0] rd_data,
    input logic             rd_valid,
    input logic             crc_err,
    input logic             dev_err,
    input logic             spi_sclk,
    input logic             spi_cs_n,
    input logic             spi_mosi
);
    localparam int HW = $clog2(GAP_CYCLES + 2);

    logic [HW-1:0] high_cnt_q;
    logic [6:0]    rise_cnt_q;
    logic          sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_cnt_q  <= HW'(GAP_CYCLES);
            rise_cnt_q  <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= spi_sclk;
            if (!spi_cs_n)                        high_cnt_q <= '0;
            else if (high_cnt_q < HW'(GAP_CYCLES)) high_cnt_q <= high_cnt_q + 1'b1;
            if (spi_cs_n)                         rise_cnt_q <= '0;
            else if (spi_sclk && !sclk_prev_q)    rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    // R4
    gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (high_cnt_q >= HW'(GAP_CYCLES)));

    // R4
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (rise_cnt_q == 7'd32));

    // R5
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R5
    mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rd_data, rd_valid, crc_err, dev_err}) |-> done);

    // R7
    crc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> !rd_valid);

    // R8
    dev_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_err |-> rd_valid);
endmodule

bind spi_frame_engine spi_frame_engine_chk #(
    .GAP_CYCLES (GAP_CYCLES),
    .OUT_W      (OUT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .crc_err  (crc_err),
    .dev_err  (dev_err),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi)
);

// File: tb/spi_frame_engine_test.sv
`timescale 1ns/1ps
module spi_frame_engine_test;
    localparam int CLK_DIV = 2;
    localparam int GAP     = 20;
    localparam int OUT_W   = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             wr_en = 1'b0;
    logic [4:0]       reg_addr = '0;
    logic [15:0]      wr_data = '0;
    logic             busy, done, rd_valid, crc_err, dev_err;
    logic [OUT_W-1:0] rd_data;
    logic             spi_sclk, spi_cs_n, spi_mosi;
    logic             spi_miso = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    spi_frame_engine #(
        .CLK_DIV    (CLK_DIV),
        .GAP_CYCLES (GAP),
        .OUT_W      (OUT_W)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .busy     (busy),
        .done     (done),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .crc_err  (crc_err),
        .dev_err  (dev_err),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

    // ---------------- sensor bus model ----------------
    logic [31:0] reply_word = '0;
    logic [31:0] out_sh = '0;
    logic [31:0] in_sh = '0;
    logic [31:0] req_cap = '0;
    logic [31:0] rsp_cap = '0;
    int frame_n = 0;
    int rises = 0;
    int last_rises = 0;
    int high_run = 0;
    int last_gap = 0;

    always @(negedge spi_cs_n) begin
        out_sh   = (frame_n % 2 == 1) ? reply_word : 32'h0;
        spi_miso = out_sh[31];
        in_sh    = '0;
        rises    = 0;
        if (frame_n % 2 == 1) last_gap = high_run;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        in_sh = {in_sh[30:0], spi_mosi};
        rises++;
    end

    always @(negedge spi_sclk) if (!spi_cs_n) begin
        out_sh   = {out_sh[30:0], 1'b0};
        spi_miso = out_sh[31];
    end

    always @(posedge spi_cs_n) if (rst_n) begin
        if (frame_n % 2 == 0) req_cap = in_sh;
        else                  rsp_cap = in_sh;
        last_rises = rises;
        frame_n++;
    end

    always @(negedge clk) begin
        if (spi_cs_n) high_run++;
        else          high_run = 0;
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] ref_crc(input logic [23:0] b);
        logic [7:0] c = 8'hFF;
        for (int i = 23; i >= 0; i--) begin
            logic fb = c[7] ^ b[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h1D;
        end
        return ~c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        finish_run();
    end

    // one access; returns after the done cycle has been sampled
    task automatic do_access(input bit wr, input logic [4:0] a, input logic [15:0] d,
                             input logic [1:0] rs, input logic [15:0] pay,
                             input bit corrupt);
        logic [7:0]  op;
        logic [31:0] exp_req;
        logic [7:0]  rcrc;
        bit          ok_crc;
        int          f0;
        int          t;
        op      = {wr, a, 2'b00};
        exp_req = {op, d, ref_crc({op, d})};
        rcrc    = ref_crc({6'h0, rs, pay});
        ok_crc  = !corrupt;
        reply_word = {6'h0, rs, pay, corrupt ? ~rcrc : rcrc};
        f0 = frame_n;
        @(negedge clk);
        wr_en = wr; reg_addr = a; wr_data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 busy after start", {31'h0, busy}, 32'h1);
        t = 0;
        while (done !== 1'b1 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done === 1'b1, "R9 done seen", {31'h0, done}, 32'h1);
        chk(busy === 1'b0, "R9 busy low at done", {31'h0, busy}, 32'h0);
        chk(frame_n - f0 == 2, "R4 two frames", frame_n - f0, 2);
        // R1 R2 request frame contents
        chk(req_cap === exp_req, "R1/R2 request frame", req_cap, exp_req);
        chk(rsp_cap === 32'h0, "R3 reply frame mosi zero", rsp_cap, 32'h0);
        chk(last_rises == 32, "R4 sclk rises per frame", last_rises, 32);
        chk(last_gap >= GAP, "R4 inter-frame gap", last_gap, GAP);
        chk(rd_valid === ok_crc, "R6/R7 rd_valid", {31'h0, rd_valid}, {31'h0, ok_crc});
        chk(crc_err === !ok_crc, "R7 crc_err", {31'h0, crc_err}, {31'h0, !ok_crc});
        chk(dev_err === (ok_crc && rs == 2'b11), "R8 dev_err", {31'h0, dev_err},
            {31'h0, (ok_crc && rs == 2'b11)});
        if (ok_crc)
            chk(rd_data === {{16{pay[15]}}, pay}, "R6 sign-extended payload", rd_data,
                {{16{pay[15]}}, pay});
        @(negedge clk);
        chk(done === 1'b0, "R9 done one cycle", {31'h0, done}, 32'h0);
    endtask

    task automatic t_reset();
        chk(spi_cs_n === 1'b1, "R10 cs_n high", {31'h0, spi_cs_n}, 32'h1);
        chk(spi_sclk === 1'b0, "R10 sclk low", {31'h0, spi_sclk}, 32'h0);
        chk(busy === 1'b0 && done === 1'b0, "R10 busy/done low", {30'h0, busy, done}, 32'h0);
        chk({rd_valid, crc_err, dev_err} === 3'b000, "R10 flags low",
            {29'h0, rd_valid, crc_err, dev_err}, 32'h0);
    endtask

    task automatic t_read_positive();
        do_access(1'b0, 5'h10, 16'h0000, 2'b01, 16'h1234, 1'b0);
    endtask

    task automatic t_read_negative();
        do_access(1'b0, 5'h01, 16'h0000, 2'b01, 16'h8001, 1'b0);
    endtask

    task automatic t_write_top_addr();
        do_access(1'b1, 5'h1F, 16'hA55A, 2'b00, 16'h7FFF, 1'b0);
    endtask

    task automatic t_bad_crc();
        do_access(1'b0, 5'h06, 16'h0000, 2'b11, 16'hFFFF, 1'b1);
    endtask

    task automatic t_dev_fault();
        do_access(1'b0, 5'h0D, 16'h0000, 2'b11, 16'h0020, 1'b0);
        do_access(1'b0, 5'h0D, 16'h0000, 2'b10, 16'h0003, 1'b0);
    endtask

    // start pulses while busy must leave the access untouched
    task automatic t_start_while_busy();
        logic [7:0]  op;
        logic [31:0] exp_req;
        int f0;
        int t;
        op      = {1'b1, 5'h0D, 2'b00};
        exp_req = {op, 16'h0020, ref_crc({op, 16'h0020})};
        reply_word = {8'h01, 16'h0001, ref_crc(24'h010001)};
        f0 = frame_n;
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 5'h0D; wr_data = 16'h0020; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        wr_en = 1'b0; reg_addr = 5'h03; wr_data = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (done !== 1'b1 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done === 1'b1, "R9 done after busy starts", {31'h0, done}, 32'h1);
        chk(req_cap === exp_req, "R9 request unchanged by busy start", req_cap, exp_req);
        repeat (300) @(negedge clk);
        chk(frame_n - f0 == 2, "R9 no extra frames", frame_n - f0, 2);
        chk(busy === 1'b0 && spi_cs_n === 1'b1, "R9 idle after ignored start",
            {30'h0, busy, spi_cs_n}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_read_positive();
        t_read_negative();
        t_write_top_addr();
        t_bad_crc();
        t_dev_fault();
        t_start_while_busy();
        do_access(1'b0, 5'h05, 16'h0000, 2'b01, 16'hFF9C, 1'b0);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule